// File: doc/BRIEF.md
# Pipelined Floating-Point Adder (four stages)

This block adds two non-negative floating-point operands in a linear pipeline that is four register stages deep. Each operand holds an unsigned binary fraction with the point to the left of its most significant bit (value `frac / 2^FRAC_W`). It has no implied leading one. Each operand also has a two's-complement exponent, so an operand is worth `frac / 2^FRAC_W * 2^exp`. The block accepts a new pair on any cycle that `in_valid` is high. The result of that pair appears, with its own valid flag, exactly four cycles later. A stream of n back-to-back pairs therefore drains in 4 + (n − 1) cycles.

The four stages work in turn. The first picks the larger exponent and measures how far apart the exponents are. The second shifts the fraction that has the smaller exponent to the right by that distance. The third adds the two fractions with one spare integer bit. The fourth normalizes the sum and fixes the exponent to match. Bits shifted out of the bottom are dropped without rounding. An exact zero sum is reported with a dedicated flag.

The block has no back-pressure, and it has no exception handling such as overflow or not-a-number. Callers keep the exponents far enough from the range limits that the result exponent still fits.

Top module: `fpa_pipe_add`

## Requirements
- R1: `out_valid` on a clock edge equals `in_valid` as sampled four rising edges earlier. Every accepted pair yields exactly one result, and idle input cycles give idle output cycles.
- R2: The result uses the larger of the two exponents as its base, whichever operand supplies it. For equal exponents, neither fraction is shifted.
- R3: The fraction with the smaller exponent is shifted right by t = |exp_a − exp_b| before the addition, and the bits it loses are truncated. When t ≥ FRAC_W (24), that fraction contributes nothing.
- R4: Let c be the aligned sum and r the larger exponent. When 2^(FRAC_W−1) ≤ c < 2^FRAC_W, the output is `out_frac = c` with `out_exp = r`.
- R5: When the sum carries into the integer bit (c ≥ 2^FRAC_W), the output is `out_frac = c >> 1`, with the lowest bit truncated, and `out_exp = r + 1`.
- R6: When 0 < c < 2^(FRAC_W−1), let u be the number of leading zeros of c in FRAC_W bits. The output is `out_frac = c << u` and `out_exp = r − u`.
- R7: A valid non-zero result always has bit FRAC_W−1 (bit 23) of `out_frac` set.
- R8: When c is exactly zero, the valid result has `out_frac = 0`, `out_exp = 0` and `out_zero = 1`. Otherwise `out_zero = 0`.
- R9: While `rst_n` is low at a rising edge, every stage is cleared. After reset, `out_valid` and `out_zero` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand pair on the inputs is to be added |
| a_frac | input | FRAC_W | Fraction of operand A, point left of bit FRAC_W−1 |
| a_exp | input | EXP_W | Exponent of operand A, two's complement |
| b_frac | input | FRAC_W | Fraction of operand B |
| b_exp | input | EXP_W | Exponent of operand B, two's complement |
| out_valid | output | 1 | Result fields hold a sum |
| out_frac | output | FRAC_W | Normalized fraction of the sum |
| out_exp | output | EXP_W | Exponent of the sum, two's complement |
| out_zero | output | 1 | Sum is exactly zero |

## Verification
The properties assume that a valid result never takes its exponent outside the EXP_W range. The carry case (r + 1) and the leading-zero case (r − u) would otherwise wrap, and the exponent relations would stop holding. The stimulus keeps every exponent between −90 and +90, so r + 1 and r − 23 both stay inside eight bits. It mixes normalized fractions, unnormalized fractions and zero fractions, so that the carry path, the left-shift path and the zero path are all reached. Directed pairs cover equal exponents, distances of 23, 24 and more, and reversed operand order.

// File: rtl/fpa_pkg.sv
// Package: fpa_pkg
// Shared defaults for the pipelined floating-point adder. The stage modules
// take their widths as parameters. These constants are the values the top
// module uses when it is instantiated without overrides.
package fpa_pkg;
    localparam int FPA_FRAC_W_DEF = 24;  // explicit fraction width, no hidden bit
    localparam int FPA_EXP_W_DEF  = 8;   // two's-complement exponent width
    localparam int FPA_DEPTH      = 4;   // register stages from input to output
endpackage

// File: rtl/fpa_exp_cmp.sv
// Module: fpa_exp_cmp (stage 1)
// Compares the two signed exponents and registers four things: the larger
// exponent, the distance between the exponents, the fraction that goes with
// the larger exponent ("big") and the fraction that goes with the smaller
// one ("small").
// Assumes: exponents in two's complement. The distance fits in EXP_W
// unsigned bits because the difference of two EXP_W-bit signed values is at
// most 2^EXP_W - 1 in magnitude.
module fpa_exp_cmp #(
    parameter int FRAC_W = 24,
    parameter int EXP_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              v_i,
    input  logic [FRAC_W-1:0] a_frac_i,
    input  logic [EXP_W-1:0]  a_exp_i,
    input  logic [FRAC_W-1:0] b_frac_i,
    input  logic [EXP_W-1:0]  b_exp_i,
    output logic              v_o,
    output logic [EXP_W-1:0]  exp_o,
    output logic [EXP_W-1:0]  dist_o,
    output logic [FRAC_W-1:0] big_o,
    output logic [FRAC_W-1:0] small_o
);
    logic              b_larger;
    logic [EXP_W-1:0]  exp_n;
    logic [EXP_W-1:0]  dist_n;
    logic [FRAC_W-1:0] big_n;
    logic [FRAC_W-1:0] small_n;

    // Choose the larger exponent and route the fractions to match it.
    always_comb begin
        b_larger = $signed(a_exp_i) < $signed(b_exp_i);
        if (b_larger) begin
            exp_n   = b_exp_i;
            dist_n  = b_exp_i - a_exp_i;
            big_n   = b_frac_i;
            small_n = a_frac_i;
        end else begin
            exp_n   = a_exp_i;
            dist_n  = a_exp_i - b_exp_i;
            big_n   = a_frac_i;
            small_n = b_frac_i;
        end
    end

    // Stage-1 register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_o     <= 1'b0;
            exp_o   <= '0;
            dist_o  <= '0;
            big_o   <= '0;
            small_o <= '0;
        end else begin
            v_o     <= v_i;
            exp_o   <= exp_n;
            dist_o  <= dist_n;
            big_o   <= big_n;
            small_o <= small_n;
        end
    end
endmodule

// File: rtl/fpa_align.sv
// Module: fpa_align (stage 2)
// Shifts the fraction of the smaller-exponent operand right by the exponent
// distance, so that both fractions share the larger exponent. Bits shifted
// out at the bottom are dropped. A distance of FRAC_W or more clears the
// shifted fraction. The larger-exponent fraction and the exponent pass
// through unchanged.
// Assumes: FRAC_W is representable in EXP_W unsigned bits.
module fpa_align #(
    parameter int FRAC_W = 24,
    parameter int EXP_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              v_i,
    input  logic [EXP_W-1:0]  exp_i,
    input  logic [EXP_W-1:0]  dist_i,
    input  logic [FRAC_W-1:0] big_i,
    input  logic [FRAC_W-1:0] small_i,
    output logic              v_o,
    output logic [EXP_W-1:0]  exp_o,
    output logic [FRAC_W-1:0] big_o,
    output logic [FRAC_W-1:0] aln_o
);
    localparam logic [EXP_W-1:0] SHIFT_LIM = EXP_W'(FRAC_W);

    logic [FRAC_W-1:0] aln_n;

    // Right shift with saturation to zero for distances beyond the width.
    always_comb begin
        if (dist_i >= SHIFT_LIM) begin
            aln_n = '0;
        end else begin
            aln_n = small_i >> dist_i;
        end
    end

    // Stage-2 register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_o   <= 1'b0;
            exp_o <= '0;
            big_o <= '0;
            aln_o <= '0;
        end else begin
            v_o   <= v_i;
            exp_o <= exp_i;
            big_o <= big_i;
            aln_o <= aln_n;
        end
    end
endmodule

// File: rtl/fpa_frac_add.sv
// Module: fpa_frac_add (stage 3)
// Adds the two aligned fractions as unsigned fixed-point values. One extra
// bit above the fraction keeps the carry, since two fractions below 1.0
// can sum to 1.0 or more.
// Assumes: both fractions are already aligned to the same exponent.
module fpa_frac_add #(
    parameter int FRAC_W = 24,
    parameter int EXP_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              v_i,
    input  logic [EXP_W-1:0]  exp_i,
    input  logic [FRAC_W-1:0] big_i,
    input  logic [FRAC_W-1:0] aln_i,
    output logic              v_o,
    output logic [EXP_W-1:0]  exp_o,
    output logic [FRAC_W:0]   sum_o
);
    logic [FRAC_W:0] sum_n;

    // Widened unsigned addition.
    always_comb begin
        sum_n = {1'b0, big_i} + {1'b0, aln_i};
    end

    // Stage-3 register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_o   <= 1'b0;
            exp_o <= '0;
            sum_o <= '0;
        end else begin
            v_o   <= v_i;
            exp_o <= exp_i;
            sum_o <= sum_n;
        end
    end
endmodule

// File: rtl/fpa_normalize.sv
// Module: fpa_normalize (stage 4)
// Brings the intermediate sum into normalized form, with the top fraction
// bit set. There are three cases:
//   carry into the integer bit -> shift right one place, exponent + 1
//   leading zeros u in fraction -> shift left u places, exponent - u
//   exact zero                  -> fraction 0, exponent 0, zero flag
// Assumes: the adjusted exponent stays inside the EXP_W range (no overflow
// detection is provided).
module fpa_normalize #(
    parameter int FRAC_W = 24,
    parameter int EXP_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              v_i,
    input  logic [EXP_W-1:0]  exp_i,
    input  logic [FRAC_W:0]   sum_i,
    output logic              v_o,
    output logic [FRAC_W-1:0] frac_o,
    output logic [EXP_W-1:0]  exp_o,
    output logic              zero_o
);
    localparam int UW = $clog2(FRAC_W + 1);

    logic [UW-1:0]     lead_zeros;
    logic [FRAC_W-1:0] frac_n;
    logic [EXP_W-1:0]  exp_n;
    logic              zero_n;

    // Leading-zero count of the fraction part; the highest set bit wins.
    always_comb begin
        lead_zeros = UW'(FRAC_W);
        for (int i = 0; i < FRAC_W; i++) begin
            if (sum_i[i]) begin
                lead_zeros = UW'(FRAC_W - 1 - i);
            end
        end
    end

    // Select the normalization case and form the result fields.
    always_comb begin
        zero_n = 1'b0;
        if (sum_i[FRAC_W]) begin
            frac_n = sum_i[FRAC_W:1];
            exp_n  = exp_i + EXP_W'(1);
        end else if (sum_i[FRAC_W-1:0] == '0) begin
            frac_n = '0;
            exp_n  = '0;
            zero_n = 1'b1;
        end else begin
            frac_n = sum_i[FRAC_W-1:0] << lead_zeros;
            exp_n  = exp_i - EXP_W'(lead_zeros);
        end
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_o    <= 1'b0;
            frac_o <= '0;
            exp_o  <= '0;
            zero_o <= 1'b0;
        end else begin
            v_o    <= v_i;
            frac_o <= frac_n;
            exp_o  <= exp_n;
            zero_o <= zero_n;
        end
    end
endmodule

// File: rtl/fpa_pipe_add.sv
// Module: fpa_pipe_add (top)
// Four-stage linear pipeline that adds two non-negative floating-point
// operands with explicit fractions. The stages are exponent compare,
// alignment, fraction add and normalize. Latency is four cycles, and one
// pair can be accepted every cycle.
// Assumes: no back-pressure; callers keep exponents away from range limits.
module fpa_pipe_add
    import fpa_pkg::*;
#(
    parameter int FRAC_W = FPA_FRAC_W_DEF,
    parameter int EXP_W  = FPA_EXP_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [FRAC_W-1:0] a_frac,
    input  logic [EXP_W-1:0]  a_exp,
    input  logic [FRAC_W-1:0] b_frac,
    input  logic [EXP_W-1:0]  b_exp,
    output logic              out_valid,
    output logic [FRAC_W-1:0] out_frac,
    output logic [EXP_W-1:0]  out_exp,
    output logic              out_zero
);
    logic              s1_valid;
    logic [EXP_W-1:0]  s1_exp;
    logic [EXP_W-1:0]  s1_dist;
    logic [FRAC_W-1:0] s1_big;
    logic [FRAC_W-1:0] s1_small;

    logic              s2_valid;
    logic [EXP_W-1:0]  s2_exp;
    logic [FRAC_W-1:0] s2_big;
    logic [FRAC_W-1:0] s2_aln;

    logic              s3_valid;
    logic [EXP_W-1:0]  s3_exp;
    logic [FRAC_W:0]   s3_sum;

    fpa_exp_cmp #(.FRAC_W(FRAC_W), .EXP_W(EXP_W)) u_cmp (
        .clk(clk), .rst_n(rst_n), .v_i(in_valid),
        .a_frac_i(a_frac), .a_exp_i(a_exp), .b_frac_i(b_frac), .b_exp_i(b_exp),
        .v_o(s1_valid), .exp_o(s1_exp), .dist_o(s1_dist),
        .big_o(s1_big), .small_o(s1_small)
    );

    fpa_align #(.FRAC_W(FRAC_W), .EXP_W(EXP_W)) u_aln (
        .clk(clk), .rst_n(rst_n), .v_i(s1_valid),
        .exp_i(s1_exp), .dist_i(s1_dist), .big_i(s1_big), .small_i(s1_small),
        .v_o(s2_valid), .exp_o(s2_exp), .big_o(s2_big), .aln_o(s2_aln)
    );

    fpa_frac_add #(.FRAC_W(FRAC_W), .EXP_W(EXP_W)) u_add (
        .clk(clk), .rst_n(rst_n), .v_i(s2_valid),
        .exp_i(s2_exp), .big_i(s2_big), .aln_i(s2_aln),
        .v_o(s3_valid), .exp_o(s3_exp), .sum_o(s3_sum)
    );

    fpa_normalize #(.FRAC_W(FRAC_W), .EXP_W(EXP_W)) u_nrm (
        .clk(clk), .rst_n(rst_n), .v_i(s3_valid),
        .exp_i(s3_exp), .sum_i(s3_sum),
        .v_o(out_valid), .frac_o(out_frac), .exp_o(out_exp), .zero_o(out_zero)
    );
endmodule

// File: rtl/fpa_pipe_add_chk.sv
// Module: fpa_pipe_add_chk
// Property checker for fpa_pipe_add. It is bound into every instance. It
// watches the ports and the registers between the stages.
// Assumes: result exponents never leave the EXP_W range.
module fpa_pipe_add_chk #(
    parameter int FRAC_W = 24,
    parameter int EXP_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [EXP_W-1:0]  a_exp,
    input logic [EXP_W-1:0]  b_exp,
    input logic              s1_valid,
    input logic [EXP_W-1:0]  s1_exp,
    input logic [EXP_W-1:0]  s1_dist,
    input logic [FRAC_W-1:0] s2_aln,
    input logic              s3_valid,
    input logic [EXP_W-1:0]  s3_exp,
    input logic [FRAC_W:0]   s3_sum,
    input logic              out_valid,
    input logic [FRAC_W-1:0] out_frac,
    input logic [EXP_W-1:0]  out_exp,
    input logic              out_zero
);
    localparam logic [EXP_W-1:0] SHIFT_LIM = EXP_W'(FRAC_W);

    logic [2:0] since_rst;

    // Count edges since reset, saturating once the pipeline is full.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_rst <= '0;
        end else if (since_rst != 3'd4) begin
            since_rst <= since_rst + 3'd1;
        end
    end

    // R1: the valid flag emerges four edges after it entered.
    p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 3'd4) |-> (out_valid == $past(in_valid, 4)));

    // R2: stage 1 holds one of the input exponents, and the larger one.
    p_max_exp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid |-> (($signed(s1_exp) >= $signed($past(a_exp))) &&
                      ($signed(s1_exp) >= $signed($past(b_exp))) &&
                      ((s1_exp == $past(a_exp)) || (s1_exp == $past(b_exp)))));

    // R3: a distance of the full width or more clears the aligned fraction.
    p_align_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && (s1_dist >= SHIFT_LIM)) |=> (s2_aln == '0));

    // R5: a carry out of the adder shifts right once and bumps the exponent.
    p_carry_exp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (s3_valid && s3_sum[FRAC_W]) |=>
            ((out_exp == EXP_W'($past(s3_exp) + 1'b1)) &&
             (out_frac == $past(s3_sum[FRAC_W:1]))));

    // R7: every non-zero result is normalized.
    p_norm_msb_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_zero) |-> out_frac[FRAC_W-1]);

    // R8: a zero result carries cleared fields and the flag.
    p_zero_fields_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_zero) |-> ((out_frac == '0) && (out_exp == '0)));
endmodule

bind fpa_pipe_add fpa_pipe_add_chk #(.FRAC_W(FRAC_W), .EXP_W(EXP_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .a_exp(a_exp), .b_exp(b_exp),
    .s1_valid(s1_valid), .s1_exp(s1_exp), .s1_dist(s1_dist),
    .s2_aln(s2_aln),
    .s3_valid(s3_valid), .s3_exp(s3_exp), .s3_sum(s3_sum),
    .out_valid(out_valid), .out_frac(out_frac), .out_exp(out_exp),
    .out_zero(out_zero)
);

// File: tb/fpa_pipe_add_bench.sv
`timescale 1ns/1ps
// Bench for fpa_pipe_add: directed corner pairs, then seeded random pairs
// with idle gaps, each compared four cycles later with a bench model.
module fpa_pipe_add_bench;
    localparam int FW = 24;
    localparam int EW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [FW-1:0] a_frac = '0;
    logic [EW-1:0] a_exp = '0;
    logic [FW-1:0] b_frac = '0;
    logic [EW-1:0] b_exp = '0;
    logic          out_valid;
    logic [FW-1:0] out_frac;
    logic [EW-1:0] out_exp;
    logic          out_zero;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    logic          h_v [8];
    logic [FW-1:0] h_f [8];
    logic [EW-1:0] h_e [8];
    logic          h_z [8];
    string         h_t [8];

    always #2 clk = ~clk;

    fpa_pipe_add u_fpa_pipe_add (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .a_frac(a_frac), .a_exp(a_exp), .b_frac(b_frac), .b_exp(b_exp),
        .out_valid(out_valid), .out_frac(out_frac), .out_exp(out_exp),
        .out_zero(out_zero)
    );

    // Bench model of the requirements; it also picks the requirement tag.
    function automatic void model(input logic [FW-1:0] af, input logic [EW-1:0] ae,
                                  input logic [FW-1:0] bf, input logic [EW-1:0] be,
                                  output logic [FW-1:0] f, output logic [EW-1:0] e,
                                  output logic z, output string tag);
        int pe = int'($signed(ae));
        int qe = int'($signed(be));
        int r, t, u, s;
        longint big, sml, c;
        if (pe >= qe) begin r = pe; t = pe - qe; big = longint'(af); sml = longint'(bf); tag = "R2"; end
        else          begin r = qe; t = qe - pe; big = longint'(bf); sml = longint'(af); tag = "R2"; end
        if (t >= FW) begin sml = 0; tag = "R3"; end
        else if (t > 0) begin sml = sml >> t; tag = "R3"; end
        c = big + sml;
        z = 1'b0;
        if (c == 0) begin
            f = '0; e = '0; z = 1'b1; tag = "R8";
        end else if (c >= (64'sd1 <<< FW)) begin
            f = FW'(c >> 1); s = r + 1; e = EW'(s); tag = "R5";
        end else begin
            u = 0;
            while (c < (64'sd1 <<< (FW - 1))) begin c = c <<< 1; u++; end
            f = FW'(c); s = r - u; e = EW'(s);
            if (u > 0) tag = "R6";
            else if (t == 0) tag = "R4";
        end
    endfunction

    // Compare the current outputs with the slot entered four steps ago.
    task automatic check_out();
        int k = (cyc + 4) % 8;
        checks++;
        if (out_valid !== h_v[k]) begin
            fails++;
            $display("FAIL R1 step %0d out_valid got %b expected %b", cyc, out_valid, h_v[k]);
        end else if (h_v[k]) begin
            if (out_frac !== h_f[k] || out_exp !== h_e[k] || out_zero !== h_z[k]) begin
                fails++;
                $display("FAIL %s step %0d got frac %h exp %0d zero %b expected frac %h exp %0d zero %b",
                         h_t[k], cyc, out_frac, $signed(out_exp), out_zero,
                         h_f[k], $signed(h_e[k]), h_z[k]);
            end
            if (!h_z[k]) begin
                checks++;
                if (out_frac[FW-1] !== 1'b1) begin
                    fails++;
                    $display("FAIL R7 step %0d msb got %b expected 1", cyc, out_frac[FW-1]);
                end
            end
        end
    endtask

    // One cycle: check at the falling edge, then present the next input.
    task automatic step(input logic v, input logic [FW-1:0] af, input int ae,
                        input logic [FW-1:0] bf, input int be);
        int k;
        @(negedge clk);
        check_out();
        k = cyc % 8;
        in_valid = v; a_frac = af; a_exp = EW'(ae); b_frac = bf; b_exp = EW'(be);
        h_v[k] = v;
        model(af, EW'(ae), bf, EW'(be), h_f[k], h_e[k], h_z[k], h_t[k]);
        cyc++;
    endtask

    initial begin
        for (int i = 0; i < 8; i++) begin h_v[i] = 1'b0; h_f[i] = '0; h_e[i] = '0; h_z[i] = 1'b0; h_t[i] = "R1"; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_zero !== 1'b0) begin
            fails++;
            $display("FAIL R9 reset got valid %b zero %b expected 0 0", out_valid, out_zero);
        end
        rst_n = 1'b1;
        // Directed corners.
        step(1, 24'h800000, 0, 24'h400000, 0);     // R4 equal exponents, no carry
        step(1, 24'h800000, 5, 24'h800000, 5);     // R5 carry: 0x800000, exp 6
        step(1, 24'hF3A000, 3, 24'hD20000, 2);     // R5 carry after one-place alignment
        step(1, 24'h400000, -2, 24'hC00000, 7);    // R2 b larger exponent
        step(1, 24'hC00000, 30, 24'hFFFFFF, 0);    // R3 distance 30, dropped
        step(1, 24'hFFFFFF, 0, 24'h800000, 24);    // R3 distance exactly 24
        step(1, 24'h800000, 23, 24'hFFFFFF, 0);    // R3 distance 23, one bit survives
        step(1, 24'h000000, 4, 24'h000000, -9);    // R8 zero sum
        step(0, 24'h123456, 1, 24'h654321, 1);     // R1 bubble
        step(1, 24'h000001, 0, 24'h000000, 0);     // R6 u = 23, exp -23
        step(1, 24'h001000, -50, 24'h000800, -50); // R6 left shift
        step(1, 24'hFFFFFF, 90, 24'hFFFFFF, 90);   // R5 near top of exponent range
        step(1, 24'h000001, -90, 24'h000000, -90); // R6 near bottom of exponent range
        // Seeded random stream with bubbles.
        void'($urandom(32'd20240611));
        for (int n = 0; n < 3000; n++) begin
            logic [FW-1:0] fa = FW'($urandom);
            logic [FW-1:0] fb = FW'($urandom);
            int sel = int'($urandom % 8);
            if (sel < 4) begin fa[FW-1] = 1'b1; fb[FW-1] = 1'b1; end
            else if (sel == 4) fa = fa >> ($urandom % 24);
            else if (sel == 5) begin fa = '0; fb = fb >> ($urandom % 24); end
            else if (sel == 6) begin fa = '0; fb = '0; end
            step(($urandom % 5) != 0, fa, int'($urandom % 181) - 90,
                 fb, int'($urandom % 181) - 90);
        end
        for (int n = 0; n < 6; n++) step(0, '0, 0, '0, 0);
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL R1 watchdog expired got running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule